// File: doc/BRIEF.md
# Instruction Decoder and ALU Execute Stage

This block is the combinational decode-and-execute slice of a small 16-bit processor with eight instructions. It takes one 16-bit instruction word and the two operand values already read from the register file. It splits the word into its fields and produces the datapath controls for the register file, the data memory and the next-PC logic. It also computes the ALU result with its zero and overflow flags. Everything settles within the same cycle, and the block holds no state.

There are three instruction formats. Register-to-register arithmetic names two sources and a destination. Load, store and branch carry a signed 4-bit offset in the low nibble. Jump carries a 12-bit offset. Loads and stores reuse the ALU adder to form the base-plus-offset address. A branch subtracts its two operands and is taken when the difference is zero. The register file, data memory and PC sequencing sit outside the block and are driven from its outputs.

Top module: `id_exec`

## Requirements
- R1: `rs_id_o` equals instruction bits 11:8, `rt_id_o` equals bits 7:4, and `jmp_off_o` equals bits 11:0, for every opcode.
- R2: For opcodes 0010 (add), 0011 (subtract), 0100 (AND) and 0101 (OR), `alu_res_o` is Rs-value op Rt-value truncated to 16 bits. The outputs also satisfy `reg_we_o`=1, `dst_rd_o`=1, `wr_id_o`=bits 3:0, `alu_imm_o`=0, `mem_to_reg_o`=0 and `mem_we_o`=0.
- R3: `zero_o` is 1 exactly when `alu_res_o` is 0.
- R4: `ovf_o` flags signed two's-complement overflow of the add or subtract the ALU performs (arithmetic, load, store and branch opcodes), and is 0 for AND and OR.
- R5: Opcode 0000 (load) gives `alu_res_o` = Rs-value + sign-extended bits 3:0. It also gives `reg_we_o`=1, `dst_rd_o`=0, `wr_id_o`=bits 7:4, `mem_to_reg_o`=1, `alu_imm_o`=1 and `mem_we_o`=0.
- R6: Opcode 0001 (store) gives `alu_res_o` = Rs-value + sign-extended bits 3:0, with `mem_we_o`=1, `alu_imm_o`=1 and `reg_we_o`=0.
- R7: `imm_o` is bits 3:0 sign-extended to 16 bits (bit 3 replicated), for every opcode.
- R8: Opcode 0111 (branch-if-equal) gives `branch_o`=1 and `alu_res_o` = Rs-value − Rt-value. `br_taken_o` is 1 exactly when the two operands are equal. Neither write enable is set.
- R9: Opcode 1000 (jump) gives `jump_o`=1, with `reg_we_o`, `mem_we_o` and `branch_o` all 0.
- R10: Opcodes 0110 and 1001 to 1111 give `reg_we_o`, `mem_we_o`, `branch_o`, `jump_o` and `br_taken_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| rs_val_i | input | 16 | Value of register named by bits 11:8 |
| rt_val_i | input | 16 | Value of register named by bits 7:4 |
| rs_id_o | output | 4 | First source register index |
| rt_id_o | output | 4 | Second source / load-store data register index |
| wr_id_o | output | 4 | Destination register index after selection |
| reg_we_o | output | 1 | Register file write enable |
| dst_rd_o | output | 1 | Destination taken from bits 3:0 (1) or bits 7:4 (0) |
| alu_imm_o | output | 1 | ALU second operand is the immediate |
| mem_we_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | Write-back from memory instead of ALU |
| branch_o | output | 1 | Conditional branch instruction |
| jump_o | output | 1 | Unconditional jump instruction |
| br_taken_o | output | 1 | Branch condition met |
| imm_o | output | 16 | Sign-extended 4-bit offset |
| jmp_off_o | output | 12 | Jump offset field |
| alu_res_o | output | 16 | ALU result or memory address |
| zero_o | output | 1 | ALU result is zero |
| ovf_o | output | 1 | Signed overflow of add/subtract |

## Verification
The bench builds the block with its default widths: 16-bit data and 4-bit register and offset fields. At these widths all sixteen opcode values can be swept directly, and the offset covers its full signed range from −8 to +7. Operand values are drawn both at random and from a pool of 0, 1, 0x7FFF, 0x8000 and 0xFFFF. This brings both signed overflow directions, results that wrap to zero and equal-operand branches within reach in a few thousand vectors.

// File: rtl/id_exec_pkg.sv
package id_exec_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LW  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_SW  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_OR  = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_BEQ = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'b1000;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    alu_imm;
    logic    mem_we;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/id_ctrl.sv
module id_ctrl
  import id_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (opc_i)
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.dst_rd = 1'b1;
        case (opc_i)
          OPC_SUB: ctrl_o.alu_op = ALU_SUB;
          OPC_AND: ctrl_o.alu_op = ALU_AND;
          OPC_OR:  ctrl_o.alu_op = ALU_OR;
          default: ctrl_o.alu_op = ALU_ADD;
        endcase
      end
      OPC_LW: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.alu_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OPC_JMP: ctrl_o.jump = 1'b1;
      default: ;  // undefined: all enables stay low
    endcase
  end
endmodule

// File: rtl/id_sext.sv
module id_sext #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int EXT_W = OUT_W - IN_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign val_o = {{EXT_W{val_i[IN_W-1]}}, val_i};
    end else begin : g_pass
      assign val_o = val_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/id_alu.sv
module id_alu
  import id_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int MSB = DATA_W - 1;

  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;

  // shared adder: subtract as a + ~b + 1
  assign is_sub = (op_i == ALU_SUB);
  assign b_eff  = is_sub ? ~b_i : b_i;
  assign sum    = a_i + b_eff + {{(DATA_W-1){1'b0}}, is_sub};

  always_comb begin
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      default: res_o = sum;
    endcase
  end

  assign zero_o = (res_o == '0);
  assign ovf_o  = (op_i == ALU_ADD || op_i == ALU_SUB) &&
                  (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
endmodule

// File: rtl/id_exec.sv
module id_exec
  import id_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RID_W  = 4,
  localparam int JMP_W   = 3 * RID_W,
  localparam int INSTR_W = OPC_W + JMP_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [RID_W-1:0]   rs_id_o,
  output logic [RID_W-1:0]   rt_id_o,
  output logic [RID_W-1:0]   wr_id_o,
  output logic               reg_we_o,
  output logic               dst_rd_o,
  output logic               alu_imm_o,
  output logic               mem_we_o,
  output logic               mem_to_reg_o,
  output logic               branch_o,
  output logic               jump_o,
  output logic               br_taken_o,
  output logic [DATA_W-1:0]  imm_o,
  output logic [JMP_W-1:0]   jmp_off_o,
  output logic [DATA_W-1:0]  alu_res_o,
  output logic               zero_o,
  output logic               ovf_o
);
  logic [OPC_W-1:0]  opc;
  logic [RID_W-1:0]  rd_id;
  logic [DATA_W-1:0] alu_b;
  ctrl_t             ctrl;

  assign opc       = instr_i[INSTR_W-1 -: OPC_W];
  assign rs_id_o   = instr_i[3*RID_W-1 -: RID_W];
  assign rt_id_o   = instr_i[2*RID_W-1 -: RID_W];
  assign rd_id     = instr_i[RID_W-1:0];
  assign jmp_off_o = instr_i[JMP_W-1:0];

  id_ctrl u_ctrl (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  id_sext #(.IN_W(RID_W), .OUT_W(DATA_W)) u_sext (
    .val_i (rd_id),
    .val_o (imm_o)
  );

  assign alu_b = ctrl.alu_imm ? imm_o : rt_val_i;

  id_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i    (rs_val_i),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res_o),
    .zero_o (zero_o),
    .ovf_o  (ovf_o)
  );

  assign wr_id_o      = ctrl.dst_rd ? rd_id : rt_id_o;
  assign reg_we_o     = ctrl.reg_we;
  assign dst_rd_o     = ctrl.dst_rd;
  assign alu_imm_o    = ctrl.alu_imm;
  assign mem_we_o     = ctrl.mem_we;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign branch_o     = ctrl.branch;
  assign jump_o       = ctrl.jump;
  assign br_taken_o   = ctrl.branch & zero_o;
endmodule

// File: rtl/id_exec_chk.sv
module id_exec_chk
  import id_exec_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RID_W   = 4,
  parameter int INSTR_W = 16
) (
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  rs_val_i,
  input logic [DATA_W-1:0]  rt_val_i,
  input logic [RID_W-1:0]   wr_id_o,
  input logic               reg_we_o,
  input logic               mem_we_o,
  input logic               mem_to_reg_o,
  input logic               alu_imm_o,
  input logic               branch_o,
  input logic               jump_o,
  input logic               br_taken_o,
  input logic               ovf_o
);
  logic [OPC_W-1:0] opc;
  logic             undef_op;
  logic             logic_op;

  assign opc      = instr_i[INSTR_W-1 -: OPC_W];
  assign logic_op = (opc == OPC_AND) || (opc == OPC_OR);
  assign undef_op = (opc == 4'b0110) || (opc > OPC_JMP);

  always_comb begin
    // R2
    arith_dst_chk: assert (!(reg_we_o && !mem_to_reg_o) || wr_id_o == instr_i[RID_W-1:0]);
    // R5
    load_dst_chk: assert (!mem_to_reg_o || (reg_we_o && alu_imm_o && wr_id_o == instr_i[2*RID_W-1 -: RID_W]));
    // R6
    store_no_wr_chk: assert (!mem_we_o || (!reg_we_o && alu_imm_o));
    // R4
    logic_no_ovf_chk: assert (!logic_op || !ovf_o);
    // R8
    branch_eq_chk: assert (!branch_o || (br_taken_o == (rs_val_i == rt_val_i)));
    // R9
    excl_ctrl_chk: assert ($onehot0({reg_we_o, mem_we_o, branch_o, jump_o}));
    // R10
    undef_idle_chk: assert (!undef_op || !(reg_we_o || mem_we_o || branch_o || jump_o || br_taken_o));
  end
endmodule

bind id_exec id_exec_chk #(.DATA_W(DATA_W), .RID_W(RID_W), .INSTR_W(INSTR_W)) u_chk (
  .instr_i      (instr_i),
  .rs_val_i     (rs_val_i),
  .rt_val_i     (rt_val_i),
  .wr_id_o      (wr_id_o),
  .reg_we_o     (reg_we_o),
  .mem_we_o     (mem_we_o),
  .mem_to_reg_o (mem_to_reg_o),
  .alu_imm_o    (alu_imm_o),
  .branch_o     (branch_o),
  .jump_o       (jump_o),
  .br_taken_o   (br_taken_o),
  .ovf_o        (ovf_o)
);

// File: tb/id_exec_bench.sv
module id_exec_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] instr_i, rs_val_i, rt_val_i;
  logic [3:0]  rs_id_o, rt_id_o, wr_id_o;
  logic        reg_we_o, dst_rd_o, alu_imm_o, mem_we_o, mem_to_reg_o;
  logic        branch_o, jump_o, br_taken_o, zero_o, ovf_o;
  logic [15:0] imm_o, alu_res_o;
  logic [11:0] jmp_off_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  id_exec u_id_exec (
    .instr_i(instr_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .rs_id_o(rs_id_o), .rt_id_o(rt_id_o), .wr_id_o(wr_id_o),
    .reg_we_o(reg_we_o), .dst_rd_o(dst_rd_o), .alu_imm_o(alu_imm_o),
    .mem_we_o(mem_we_o), .mem_to_reg_o(mem_to_reg_o), .branch_o(branch_o),
    .jump_o(jump_o), .br_taken_o(br_taken_o), .imm_o(imm_o),
    .jmp_off_o(jmp_off_o), .alu_res_o(alu_res_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (instr %h rs %h rt %h)",
               req, what, act, exp, instr_i, rs_val_i, rt_val_i);
    end
  endtask

  function automatic logic [15:0] sx4(input logic [3:0] v);
    return {{12{v[3]}}, v};
  endfunction

  task automatic apply(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b);
    logic [3:0]  op;
    logic [15:0] e_res, e_imm;
    logic        e_ovf, e_we, e_mwe, e_br, e_jmp, is_arith, is_logic;
    @(negedge clk);
    instr_i = ins; rs_val_i = a; rt_val_i = b;
    #2;
    op    = ins[15:12];
    e_imm = sx4(ins[3:0]);
    e_ovf = 1'b0;
    e_res = 16'h0;
    is_arith = (op >= 4'd2 && op <= 4'd5);
    is_logic = (op == 4'd4 || op == 4'd5);
    case (op)
      4'd2: begin e_res = a + b; e_ovf = (a[15] == b[15]) && (e_res[15] != a[15]); end
      4'd3, 4'd7: begin e_res = a - b; e_ovf = (a[15] != b[15]) && (e_res[15] != a[15]); end
      4'd4: e_res = a & b;
      4'd5: e_res = a | b;
      4'd0, 4'd1: begin e_res = a + e_imm; e_ovf = (a[15] == e_imm[15]) && (e_res[15] != a[15]); end
      default: ;
    endcase
    e_we  = is_arith || op == 4'd0;
    e_mwe = (op == 4'd1);
    e_br  = (op == 4'd7);
    e_jmp = (op == 4'd8);
    // R1
    check("R1", "rs_id", rs_id_o, ins[11:8]);
    check("R1", "rt_id", rt_id_o, ins[7:4]);
    check("R1", "jmp_off", jmp_off_o, ins[11:0]);
    // R7
    check("R7", "imm", imm_o, e_imm);
    if (is_arith) begin
      // R2
      check("R2", "alu_res", alu_res_o, e_res);
      check("R2", "ctrl", {reg_we_o, dst_rd_o, alu_imm_o, mem_to_reg_o, mem_we_o}, 5'b11000);
      check("R2", "wr_id", wr_id_o, ins[3:0]);
    end else if (op == 4'd0) begin
      // R5
      check("R5", "addr", alu_res_o, e_res);
      check("R5", "ctrl", {reg_we_o, dst_rd_o, alu_imm_o, mem_to_reg_o, mem_we_o}, 5'b10110);
      check("R5", "wr_id", wr_id_o, ins[7:4]);
    end else if (op == 4'd1) begin
      // R6
      check("R6", "addr", alu_res_o, e_res);
      check("R6", "ctrl", {mem_we_o, alu_imm_o, reg_we_o}, 3'b110);
    end else if (op == 4'd7) begin
      // R8
      check("R8", "diff", alu_res_o, e_res);
      check("R8", "ctrl", {branch_o, br_taken_o, reg_we_o, mem_we_o}, {1'b1, a == b, 2'b00});
    end else if (op == 4'd8) begin
      // R9
      check("R9", "ctrl", {jump_o, reg_we_o, mem_we_o, branch_o}, 4'b1000);
    end else begin
      // R10
      check("R10", "ctrl", {reg_we_o, mem_we_o, branch_o, jump_o, br_taken_o}, 5'b00000);
    end
    if (is_arith || op <= 4'd1 || op == 4'd7) begin
      // R3
      check("R3", "zero", zero_o, alu_res_o == 16'h0);
      // R4
      check("R4", "ovf", ovf_o, is_logic ? 1'b0 : e_ovf);
    end
    // R8 R9 R10: control lines outside their own opcodes
    check("R10", "enables", {reg_we_o, mem_we_o, branch_o, jump_o}, {e_we, e_mwe, e_br, e_jmp});
  endtask

  function automatic logic [15:0] pick_val();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [15:0] ins, a, b;
    void'($urandom(32'd4711));
    instr_i = 16'h0; rs_val_i = 16'h0; rt_val_i = 16'h0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero word decodes as a load of zero
    @(negedge clk); #2;
    check("R5", "reset addr", alu_res_o, 16'h0);
    check("R5", "reset ctrl", {reg_we_o, mem_to_reg_o, mem_we_o, branch_o, jump_o}, 5'b11000);

    // directed corners
    apply(16'h2368, 16'h7FFF, 16'h0001);  // R4 add positive overflow
    apply(16'h2368, 16'h8000, 16'hFFFF);  // R4 add negative overflow
    apply(16'h3123, 16'h8000, 16'h0001);  // R4 sub overflow
    apply(16'h3123, 16'h1234, 16'h1234);  // R3 zero result
    apply(16'h4456, 16'hFFFF, 16'h7FFF);  // R4 logic, no overflow
    apply(16'h5456, 16'h0F0F, 16'hF0F0);  // R2 OR
    apply(16'h034F, 16'h0010, 16'h0000);  // R5 offset -1
    apply(16'h1347, 16'h0010, 16'hAAAA);  // R6 offset +7
    apply(16'h0348, 16'h0000, 16'h0000);  // R5 offset -8
    apply(16'h712E, 16'h5555, 16'h5555);  // R8 taken
    apply(16'h712E, 16'h5555, 16'h5554);  // R8 not taken
    apply(16'h8ABC, 16'h0000, 16'h0000);  // R9
    apply(16'h6123, 16'h0000, 16'h0000);  // R10
    apply(16'hF123, 16'h7777, 16'h7777);  // R10 equal operands, no branch

    for (int op = 0; op < 16; op++)
      for (int off = 0; off < 16; off++)
        apply({op[3:0], 4'h3, 4'h5, off[3:0]}, pick_val(), pick_val());

    for (int i = 0; i < 3000; i++) begin
      ins = 16'($urandom);
      a   = pick_val();
      b   = ($urandom % 4 == 0) ? a : pick_val();
      apply(ins, a, b);
    end
    finish_run();
  end
endmodule